// File: doc/BRIEF.md
# Credit-Based Virtual-Circuit Packet Transmitter

This block sends fixed-size packets from a local node onto a byte-wide switch link. Packets are written into a small transmit queue as a destination node ID plus an eight-byte payload. For the packet at the head of the queue, the block maps the destination to a virtual-circuit (VC) number using a static table. It then checks a one-bit credit for that circuit. Each circuit has exactly one buffer slot downstream, so a set credit means the slot is free.

When the credit is set, the block sends the packet and clears the credit. The link carries the VC number as a header byte, marked by a flag bit, followed by the eight payload bytes. When the credit is clear, the packet is not left waiting at the head. It is written back to the tail of the queue, so packets for other circuits can pass it. A separate credit port, made of a valid bit and a VC number, sets the credit bit of the circuit it names.

The controller is a four-state machine:
- **ST_IDLE** moves to **ST_PICK** when the queue is not empty.
- **ST_PICK** looks up the head packet. It takes the *grant* transition to **ST_HEAD**, popping the packet and clearing its credit. Otherwise it takes the *recycle* transition back to **ST_IDLE**, popping the packet and pushing it again at the tail in the same cycle.
- **ST_HEAD** drives the header byte and moves to **ST_BODY**.
- **ST_BODY** drives one payload byte per cycle. After the last byte it takes the *done* transition back to **ST_IDLE**.

Top module: `vcx_link_tx`

## Requirements
- R1: After reset every credit bit is 1, `link_flag` and `link_data` are 0, and `in_ready` is 1.
- R2: The header byte of a packet equals (dest × MAP_MUL + MAP_ADD) mod 2^VC_W; with the defaults 37 and 5, dest 1 maps to 42, dest 2 to 79 and dest 3 to 116.
- R3: A packet is sent as one header cycle with `link_flag`=1, then 8 consecutive cycles with `link_flag`=0 carrying payload bytes 0 to 7. Byte 0 is `in_payload[7:0]`, the least significant byte.
- R4: Granting a packet clears the credit of its circuit. A later packet to that circuit is not sent until a credit arrives for that circuit. A header is sent only on a circuit whose credit was set.
- R5: When `cr_valid` is 1 at a clock edge, the credit bit of circuit `cr_vc` is 1 afterwards.
- R6: A packet whose circuit has no credit moves to the tail of the queue. A packet queued behind it for a circuit that has credit is sent first.
- R7: If a credit arrives for a circuit in the same cycle that a grant clears that circuit, the credit bit ends up set.
- R8: When no packet is in flight, `link_flag` and `link_data` are 0. No header starts in the cycle after the queue is seen empty.
- R9: `in_ready` is 0 while the queue holds DEPTH packets. It is also 0 in a recycle cycle, because the single queue write port is busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Offer a packet to the transmit queue |
| in_dest | input | NODE_W | Destination node ID of the offered packet |
| in_payload | input | PAY_BYTES*8 | Payload; byte 0 in bits 7:0 |
| in_ready | output | 1 | Queue accepts the offered packet this cycle |
| cr_valid | input | 1 | A credit is returned this cycle |
| cr_vc | input | VC_W | Circuit the returned credit belongs to |
| link_flag | output | 1 | High only on the header byte |
| link_data | output | 8 | Link byte: VC number, payload byte, or 0 when idle |

## Verification
The bench uses the default parameters: DEPTH=4, NODE_W=4, VC_W=8, and map constants 37 and 5. With a depth of four, the full-queue condition is reached after only four pushes of blocked packets. With 256 circuits and an odd multiplier, destinations 1, 2 and 3 fall on distinct circuits whose credits can be run down one at a time. This setup covers several cases: a blocked packet being overtaken, a full queue that keeps rotating while all its packets are blocked, and a credit returned on the exact edge where a grant clears the same circuit.

// File: rtl/vcx_pkg.sv
package vcx_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_PICK,
        ST_HEAD,
        ST_BODY
    } tx_state_e;
endpackage

// File: rtl/vcx_fifo.sv
module vcx_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         rd_en,
    output logic [W-1:0] rd_data,
    output logic         empty,
    output logic         full
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] rd_ptr, wr_ptr;
    logic [CW-1:0] count;
    logic          do_rd, do_wr;

    function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    assign empty   = (count == '0);
    assign full    = (count == CW'(DEPTH));
    assign do_rd   = rd_en && !empty;
    assign do_wr   = wr_en && (!full || do_rd);
    assign rd_data = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (do_wr) mem[wr_ptr] <= wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_rd) rd_ptr <= nxt(rd_ptr);
            if (do_wr) wr_ptr <= nxt(wr_ptr);
            unique case ({do_wr, do_rd})
                2'b10:   count <= count + CW'(1);
                2'b01:   count <= count - CW'(1);
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/vcx_vc_rom.sv
module vcx_vc_rom #(
    parameter int NODE_W  = 4,
    parameter int VC_W    = 8,
    parameter int MAP_MUL = 37,
    parameter int MAP_ADD = 5
) (
    input  logic [NODE_W-1:0] dest,
    output logic [VC_W-1:0]   vc
);
    localparam int N_NODE = 1 << NODE_W;
    localparam int N_VC   = 1 << VC_W;

    logic [VC_W-1:0] tbl [N_NODE];

    for (genvar i = 0; i < N_NODE; i++) begin : g_ent
        assign tbl[i] = VC_W'((i * MAP_MUL + MAP_ADD) % N_VC);
    end

    assign vc = tbl[dest];
endmodule

// File: rtl/vcx_credit_mem.sv
module vcx_credit_mem #(
    parameter int VC_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_en,
    input  logic [VC_W-1:0]   clr_vc,
    input  logic              set_en,
    input  logic [VC_W-1:0]   set_vc,
    output logic [(1<<VC_W)-1:0] bits
);
    // The clear is written first and the set second, so a set wins on a collision.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bits <= '1;
        end else begin
            if (clr_en) bits[clr_vc] <= 1'b0;
            if (set_en) bits[set_vc] <= 1'b1;
        end
    end
endmodule

// File: rtl/vcx_link_tx.sv
module vcx_link_tx
    import vcx_pkg::*;
#(
    parameter int NODE_W    = 4,
    parameter int VC_W      = 8,
    parameter int PAY_BYTES = 8,
    parameter int DEPTH     = 4,
    parameter int MAP_MUL   = 37,
    parameter int MAP_ADD   = 5
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      in_valid,
    input  logic [NODE_W-1:0]         in_dest,
    input  logic [PAY_BYTES*8-1:0]    in_payload,
    output logic                      in_ready,
    input  logic                      cr_valid,
    input  logic [VC_W-1:0]           cr_vc,
    output logic                      link_flag,
    output logic [7:0]                link_data
);
    localparam int PAY_W = PAY_BYTES * BYTE_W;
    localparam int ENT_W = NODE_W + PAY_W;
    localparam int CNT_W = (PAY_BYTES > 1) ? $clog2(PAY_BYTES) : 1;
    localparam int N_VC  = 1 << VC_W;

    tx_state_e st, st_nx;

    logic              q_wr, q_rd, q_empty, q_full;
    logic [ENT_W-1:0]  q_wdata, q_head;
    logic [NODE_W-1:0] head_dest;
    logic [PAY_W-1:0]  head_pay;
    logic [VC_W-1:0]   pick_vc;
    logic [N_VC-1:0]   cr_bits;
    logic              credit_ok, grant, recycle;

    logic [VC_W-1:0]   vc_q;
    logic [PAY_W-1:0]  pay_q;
    logic [CNT_W-1:0]  cnt;

    assign head_dest = q_head[ENT_W-1 -: NODE_W];
    assign head_pay  = q_head[PAY_W-1:0];
    assign credit_ok = cr_bits[pick_vc];
    assign grant     = (st == ST_PICK) && credit_ok;
    assign recycle   = (st == ST_PICK) && !credit_ok;

    // The queue has one write port, shared by new packets and recycled ones.
    assign in_ready = !q_full && !recycle;
    assign q_rd     = grant || recycle;
    assign q_wr     = recycle || (in_valid && in_ready);
    assign q_wdata  = recycle ? q_head : {in_dest, in_payload};

    vcx_fifo #(.W(ENT_W), .DEPTH(DEPTH)) u_q (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (q_wr),
        .wr_data (q_wdata),
        .rd_en   (q_rd),
        .rd_data (q_head),
        .empty   (q_empty),
        .full    (q_full)
    );

    vcx_vc_rom #(
        .NODE_W(NODE_W), .VC_W(VC_W), .MAP_MUL(MAP_MUL), .MAP_ADD(MAP_ADD)
    ) u_map (
        .dest (head_dest),
        .vc   (pick_vc)
    );

    vcx_credit_mem #(.VC_W(VC_W)) u_cred (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_en (grant),
        .clr_vc (pick_vc),
        .set_en (cr_valid),
        .set_vc (cr_vc),
        .bits   (cr_bits)
    );

    // Next-state selection
    always_comb begin
        st_nx = st;
        unique case (st)
            ST_IDLE: if (!q_empty) st_nx = ST_PICK;
            ST_PICK: st_nx = credit_ok ? ST_HEAD : ST_IDLE;
            ST_HEAD: st_nx = ST_BODY;
            ST_BODY: if (cnt == CNT_W'(PAY_BYTES - 1)) st_nx = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nx;
    end

    // Packet holding registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vc_q  <= '0;
            pay_q <= '0;
            cnt   <= '0;
        end else begin
            if (grant) begin
                vc_q  <= pick_vc;
                pay_q <= head_pay;
                cnt   <= '0;
            end else if (st == ST_BODY) begin
                pay_q <= pay_q >> BYTE_W;
                cnt   <= cnt + CNT_W'(1);
            end
        end
    end

    // Link outputs
    always_comb begin
        link_flag = 1'b0;
        link_data = '0;
        unique case (st)
            ST_IDLE: ;
            ST_PICK: ;
            ST_HEAD: begin
                link_flag = 1'b1;
                link_data = 8'(vc_q);
            end
            ST_BODY: link_data = pay_q[BYTE_W-1:0];
        endcase
    end
endmodule

// File: rtl/vcx_link_tx_chk.sv
module vcx_link_tx_chk #(
    parameter int VC_W = 8
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  link_flag,
    input logic [7:0]            link_data,
    input logic                  cr_valid,
    input logic [VC_W-1:0]       cr_vc,
    input logic [(1<<VC_W)-1:0]  cr_bits,
    input logic                  q_full,
    input logic                  q_empty,
    input logic                  in_ready,
    input logic                  grant,
    input logic [VC_W-1:0]       pick_vc
);
    logic [(1<<VC_W)-1:0] prev_bits;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_bits <= '1;
        else        prev_bits <= cr_bits;
    end

    // R3
    hdr_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        link_flag |=> !link_flag);

    // R4
    grant_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grant && !(cr_valid && cr_vc == pick_vc)) |=> !cr_bits[$past(pick_vc)]);

    // R4
    hdr_credit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        link_flag |-> prev_bits[VC_W'(link_data)]);

    // R5
    credit_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cr_valid |=> cr_bits[$past(cr_vc)]);

    // R7
    collide_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grant && cr_valid && cr_vc == pick_vc) |=> cr_bits[$past(pick_vc)]);

    // R8
    idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q_empty |=> !link_flag);

    // R9
    full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q_full |-> !in_ready);
endmodule

bind vcx_link_tx vcx_link_tx_chk #(.VC_W(VC_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .link_flag (link_flag),
    .link_data (link_data),
    .cr_valid  (cr_valid),
    .cr_vc     (cr_vc),
    .cr_bits   (cr_bits),
    .q_full    (q_full),
    .q_empty   (q_empty),
    .in_ready  (in_ready),
    .grant     (grant),
    .pick_vc   (pick_vc)
);

// File: tb/sim_vcx_link_tx.sv
`timescale 1ns/1ps
module sim_vcx_link_tx;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [3:0]  in_dest = '0;
    logic [63:0] in_payload = '0;
    logic        in_ready;
    logic        cr_valid = 1'b0;
    logic [7:0]  cr_vc = '0;
    logic        link_flag;
    logic [7:0]  link_data;

    always #2 clk = ~clk;

    vcx_link_tx u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_dest(in_dest),
        .in_payload(in_payload), .in_ready(in_ready), .cr_valid(cr_valid),
        .cr_vc(cr_vc), .link_flag(link_flag), .link_data(link_data)
    );

    typedef struct { logic [7:0] vc; logic [63:0] pay; } exp_t;
    exp_t exp_q[$];

    int n_chk = 0, n_fail = 0, rx_cnt = 0, cyc = 0;
    bit done = 0;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] vc_of(input int d);
        return 8'((d * 37 + 5) % 256);
    endfunction

    // Scoreboard driver side
    task automatic expect_pkt(input logic [7:0] vc, input logic [63:0] pay);
        exp_t e;
        e.vc = vc; e.pay = pay;
        exp_q.push_back(e);
    endtask

    task automatic push_pkt(input logic [3:0] d, input logic [63:0] pay);
        @(negedge clk);
        in_valid = 1'b1; in_dest = d; in_payload = pay;
        while (!in_ready) @(negedge clk);
        @(posedge clk);
        #1 in_valid = 1'b0;
    endtask

    task automatic credit_pulse(input logic [7:0] v);
        @(negedge clk);
        cr_valid = 1'b1; cr_vc = v;
        @(negedge clk);
        cr_valid = 1'b0;
    endtask

    task automatic wait_rx(input int n, input int limit, input string tag);
        for (int i = 0; i < limit && rx_cnt < n; i++) @(negedge clk);
        chk(rx_cnt >= n, tag, rx_cnt, n);
    endtask

    // Monitor: captures packets from the link and compares them in order
    logic        cap = 1'b0;
    int          bidx = 0;
    logic [7:0]  hv;
    logic [63:0] acc;
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (cap) begin
                chk(link_flag == 1'b0, "R3 flag low on payload byte", link_flag, 0);
                acc[bidx*8 +: 8] = link_data;
                bidx++;
                if (bidx == 8) begin
                    cap = 1'b0;
                    rx_cnt++;
                    if (exp_q.size() == 0) begin
                        chk(1'b0, "R6 unexpected packet", hv, 0);
                    end else begin
                        exp_t e;
                        e = exp_q.pop_front();
                        chk(hv == e.vc, "R2 header VC", hv, e.vc);
                        chk(acc == e.pay, "R3 payload bytes", acc, e.pay);
                    end
                end
            end else if (link_flag) begin
                cap = 1'b1; bidx = 0; hv = link_data; acc = '0;
            end else begin
                chk(link_data == 8'h00, "R8 idle link data", link_data, 0);
            end
        end
    end

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !done) begin
            done = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 100000);
            summary();
            $finish;
        end
    end

    initial begin
        int lows;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(in_ready == 1'b1, "R1 in_ready after reset", in_ready, 1);
        chk(link_flag == 1'b0, "R1 flag after reset", link_flag, 0);
        chk(link_data == 8'h00, "R1 data after reset", link_data, 0);

        // R1/R2/R3: first packet uses the reset credit
        expect_pkt(vc_of(1), 64'h8877_6655_4433_2211);
        push_pkt(4'd1, 64'h8877_6655_4433_2211);
        wait_rx(1, 100, "R1 reset credit lets first packet go");

        // R4/R6: second packet to circuit 42 blocks, packet to circuit 79 overtakes
        push_pkt(4'd1, 64'h0102_0304_0506_0708);
        push_pkt(4'd2, 64'hA0B1_C2D3_E4F5_0617);
        expect_pkt(vc_of(2), 64'hA0B1_C2D3_E4F5_0617);
        wait_rx(2, 200, "R6 later packet overtakes blocked one");
        lows = 0;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (!in_ready) lows++;
        end
        chk(rx_cnt == 2, "R4 no send without credit", rx_cnt, 2);
        chk(lows > 0, "R9 ready drops in recycle cycle", lows, 1);

        // R5: returned credit releases the blocked packet
        expect_pkt(vc_of(1), 64'h0102_0304_0506_0708);
        credit_pulse(vc_of(1));
        wait_rx(3, 200, "R5 credit releases blocked packet");

        // R9: fill queue with packets for circuit 79 (no credit left)
        for (int k = 0; k < 4; k++) push_pkt(4'd2, 64'hDEAD_BEEF_CAFE_F00D);
        repeat (5) @(negedge clk);
        chk(in_ready == 1'b0, "R9 ready low when queue full", in_ready, 0);
        chk(rx_cnt == 3, "R4 full blocked queue sends nothing", rx_cnt, 3);
        for (int k = 0; k < 4; k++) begin
            expect_pkt(vc_of(2), 64'hDEAD_BEEF_CAFE_F00D);
            credit_pulse(vc_of(2));
            wait_rx(4 + k, 300, "R5 one credit one packet");
        end
        repeat (5) @(negedge clk);
        chk(in_ready == 1'b1, "R9 ready back after drain", in_ready, 1);

        // R7: credit held through the grant edge of circuit 116, dropped after the header
        @(negedge clk);
        cr_valid = 1'b1; cr_vc = vc_of(3);
        expect_pkt(vc_of(3), 64'h1111_2222_3333_4444);
        push_pkt(4'd3, 64'h1111_2222_3333_4444);
        while (!(link_flag && link_data == vc_of(3))) @(negedge clk);
        cr_valid = 1'b0;
        expect_pkt(vc_of(3), 64'h5555_6666_7777_8888);
        push_pkt(4'd3, 64'h5555_6666_7777_8888);
        wait_rx(9, 300, "R7 credit wins over same-cycle clear");

        repeat (20) @(negedge clk);
        chk(exp_q.size() == 0, "R6 all expected packets seen", exp_q.size(), 0);
        done = 1;
        summary();
        $finish;
    end
endmodule